// File: doc/BRIEF.md
# TCP Acknowledgment Number Reporter

This block listens, without ever driving the wire, to a mirrored copy of 100BASE-T traffic presented on an MII receive port clocked at 25 MHz. It rebuilds bytes from the nibble stream and locates the Ethernet type, the IPv4 version, header length and protocol fields, and the TCP acknowledgment and flag fields. When a frame qualifies, it keeps the acknowledgment number of that frame, which is the next sequence number the far end expects.

A free-running timer fires once per reporting interval (200 ms, or 5,000,000 cycles at 25 MHz, by default). Each time it fires, the most recent stored acknowledgment number is copied and sent as four bytes on an asynchronous serial line. A logger subtracts successive reports and divides by the interval to find the byte rate, which it then compares with the 100 Mbit/s line rate. Only the latest value goes out. Values seen in between are overwritten.

Top module: `tcp_ack_reporter`

## Requirements
- R1: During and after reset the serial output idles high, and the stored acknowledgment number is zero. A report sent before any qualifying frame carries 0x00000000.
- R2: Nibbles are taken only while the data-valid input is high, low nibble first. Byte counting begins after a nibble 0x5 is directly followed by a nibble 0xD (the 0xD5 delimiter), whatever the preamble length.
- R3: A frame qualifies only if frame bytes 12 and 13 are 0x08 and 0x00, the upper nibble of byte 14 is 4 with a lower nibble (header length in 32-bit words) of at least 5, and byte 23 is 6.
- R4: The TCP header starts at byte 14 + 4 × header length. The acknowledgment number is TCP bytes 8 to 11, most significant first, and the flags are TCP byte 13.
- R5: The stored value changes only at the end of a qualifying frame that reached TCP byte 13 with bit 4 (0x10) of that byte set and with the error input never high during the frame. Every other frame leaves the stored value unchanged.
- R6: When several qualifying frames arrive within one interval, the report carries only the value from the last of them.
- R7: Reports begin every PERIOD_CYC clock cycles. Successive start bits are exactly PERIOD_CYC cycles apart.
- R8: A report is four bytes, most significant first. Each byte is one low start bit, eight data bits LSB first and one high stop bit, and every bit lasts CLKS_PER_BIT cycles.
- R9: The value is copied when a report starts. A frame that completes while the report is being sent does not change the bytes of that report, and it appears in the next report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | MII receive clock, 25 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_rxd | input | 4 | Receive data nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| mii_rx_er | input | 1 | Receive error |
| uart_txd | output | 1 | Serial report output, idle high |

## Verification
A frame commit and a report in progress can overlap, as can a frame commit and the timer tick. The bench starts sending a frame as soon as it sees the first start bit of a report, so the frame completes while that report's bytes are still shifting out. It then checks that the report being sent still carries the earlier value and that the next report carries the new one. Because the parser runs independently of the timer, the bench also checks that the start-bit spacing stays exactly one interval while frames are being received.

// File: rtl/ackrep_pkg.sv
package ackrep_pkg;
    typedef enum logic [1:0] {NB_IDLE, NB_PRE, NB_DATA} nb_state_e;
    typedef enum logic [1:0] {RP_IDLE, RP_PUSH, RP_HOLD, RP_DRAIN} rp_state_e;
    localparam int ETH_HDR_BYTES = 14;
    localparam int IP_PROTO_IDX  = 23;
    localparam int ACK_OFFS      = 8;
    localparam int FLAG_OFFS     = 13;
endpackage

// File: rtl/ackrep_nibble_asm.sv
module ackrep_nibble_asm import ackrep_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rxd,
    input  logic       rx_dv,
    input  logic       rx_er,
    output logic       byte_vld,
    output logic [7:0] byte_dat,
    output logic       frm_end,
    output logic       frm_err
);
    typedef struct packed {
        nb_state_e  state;
        logic [3:0] prev;
        logic [3:0] lo;
        logic       phase;
        logic       err;
        logic       bvld;
        logic [7:0] bdat;
        logic       fend;
        logic       ferr;
    } nb_regs_t;

    nb_regs_t q, d;

    always_comb begin
        d      = q;
        d.bvld = 1'b0;
        d.fend = 1'b0;
        case (q.state)
            NB_IDLE: begin
                if (rx_dv) begin
                    d.state = NB_PRE;
                    d.prev  = rxd;
                    d.err   = rx_er;
                end
            end
            NB_PRE: begin
                if (!rx_dv) begin
                    d.state = NB_IDLE;
                end else begin
                    d.err  = q.err | rx_er;
                    d.prev = rxd;
                    if (q.prev == 4'h5 && rxd == 4'hD) begin
                        d.state = NB_DATA;
                        d.phase = 1'b0;
                    end
                end
            end
            NB_DATA: begin
                if (!rx_dv) begin
                    d.fend  = 1'b1;
                    d.ferr  = q.err;
                    d.state = NB_IDLE;
                end else begin
                    d.err = q.err | rx_er;
                    if (!q.phase) begin
                        d.lo    = rxd;
                        d.phase = 1'b1;
                    end else begin
                        d.bdat  = {rxd, q.lo};
                        d.bvld  = 1'b1;
                        d.phase = 1'b0;
                    end
                end
            end
            default: d.state = NB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: NB_IDLE, default: '0};
        else        q <= d;
    end

    assign byte_vld = q.bvld;
    assign byte_dat = q.bdat;
    assign frm_end  = q.fend;
    assign frm_err  = q.ferr;

    a_r2_byte_needs_dv: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(rx_dv));
    a_r2_end_after_dv_drop: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |-> !$past(rx_dv));
endmodule

// File: rtl/ackrep_frame_parser.sv
module ackrep_frame_parser import ackrep_pkg::*; #(
    parameter int IDX_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_dat,
    input  logic        frm_end,
    input  logic        frm_err,
    output logic [31:0] ack_val
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             eth_ok;
        logic             ip_ok;
        logic             proto_ok;
        logic [3:0]       ihl;
        logic [31:0]      ack_sh;
        logic             flag_ok;
        logic [31:0]      ack;
    } pr_regs_t;

    pr_regs_t q, d;
    logic [IDX_W-1:0] tcp_base;

    always_comb begin
        tcp_base = IDX_W'(ETH_HDR_BYTES) + IDX_W'({q.ihl, 2'b00});
        d = q;
        if (byte_vld) begin
            if (q.idx == IDX_W'(12)) d.eth_ok = (byte_dat == 8'h08);
            if (q.idx == IDX_W'(13)) d.eth_ok = q.eth_ok && (byte_dat == 8'h00);
            if (q.idx == IDX_W'(ETH_HDR_BYTES)) begin
                d.ip_ok = (byte_dat[7:4] == 4'h4) && (byte_dat[3:0] >= 4'h5);
                d.ihl   = byte_dat[3:0];
            end
            if (q.idx == IDX_W'(IP_PROTO_IDX)) d.proto_ok = (byte_dat == 8'h06);
            if (q.idx > IDX_W'(ETH_HDR_BYTES) &&
                q.idx >= tcp_base + IDX_W'(ACK_OFFS) &&
                q.idx <  tcp_base + IDX_W'(ACK_OFFS + 4))
                d.ack_sh = {q.ack_sh[23:0], byte_dat};
            if (q.idx > IDX_W'(ETH_HDR_BYTES) &&
                q.idx == tcp_base + IDX_W'(FLAG_OFFS))
                d.flag_ok = byte_dat[4];
            if (q.idx != '1) d.idx = q.idx + 1'b1;
        end
        if (frm_end) begin
            if (q.eth_ok && q.ip_ok && q.proto_ok && q.flag_ok && !frm_err)
                d.ack = q.ack_sh;
            d.idx      = '0;
            d.eth_ok   = 1'b0;
            d.ip_ok    = 1'b0;
            d.proto_ok = 1'b0;
            d.flag_ok  = 1'b0;
            d.ihl      = 4'h5;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ihl: 4'h5, default: '0};
        else        q <= d;
    end

    assign ack_val = q.ack;

    a_r5_errored_frame_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && frm_err) |=> $stable(ack_val));
    a_r5_only_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_end |=> $stable(ack_val));
endmodule

// File: rtl/ackrep_report_ctrl.sv
module ackrep_report_ctrl import ackrep_pkg::*; #(
    parameter int PERIOD_CYC = 5_000_000,
    localparam int CW = $clog2(PERIOD_CYC)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ack_val,
    input  logic        uart_busy,
    output logic        tx_go,
    output logic [7:0]  tx_byte
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        rp_state_e     state;
        logic [1:0]    idx;
        logic [31:0]   snap;
    } rp_regs_t;

    rp_regs_t q, d;
    logic tick;

    always_comb begin
        tick  = (q.cnt == CW'(PERIOD_CYC - 1));
        d     = q;
        d.cnt = tick ? '0 : q.cnt + 1'b1;
        case (q.state)
            RP_IDLE: begin
                if (tick) begin
                    d.snap  = ack_val;
                    d.idx   = 2'd0;
                    d.state = RP_PUSH;
                end
            end
            RP_PUSH: d.state = RP_HOLD;
            RP_HOLD: d.state = RP_DRAIN;
            RP_DRAIN: begin
                if (!uart_busy) begin
                    if (q.idx == 2'd3) begin
                        d.state = RP_IDLE;
                    end else begin
                        d.idx   = q.idx + 2'd1;
                        d.state = RP_PUSH;
                    end
                end
            end
            default: d.state = RP_IDLE;
        endcase
    end

    always_comb begin
        case (q.idx)
            2'd0:    tx_byte = q.snap[31:24];
            2'd1:    tx_byte = q.snap[23:16];
            2'd2:    tx_byte = q.snap[15:8];
            default: tx_byte = q.snap[7:0];
        endcase
    end
    assign tx_go = (q.state == RP_PUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: RP_IDLE, default: '0};
        else        q <= d;
    end

    a_r9_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != RP_IDLE && $past(q.state) != RP_IDLE) |-> $stable(q.snap));
    a_r7_start_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RP_PUSH && $past(q.state) == RP_IDLE) |-> $past(tick));
endmodule

// File: rtl/ackrep_uart_tx.sv
module ackrep_uart_tx #(
    parameter int CLKS_PER_BIT = 217,
    localparam int BW = $clog2(CLKS_PER_BIT)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] din,
    output logic       busy,
    output logic       txd
);
    typedef struct packed {
        logic          busy;
        logic [9:0]    sh;
        logic [BW-1:0] bcnt;
        logic [3:0]    nbit;
    } ut_regs_t;

    ut_regs_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (go) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, din, 1'b0};
                d.bcnt = '0;
                d.nbit = 4'd0;
            end
        end else if (q.bcnt == BW'(CLKS_PER_BIT - 1)) begin
            d.bcnt = '0;
            d.sh   = {1'b1, q.sh[9:1]};
            if (q.nbit == 4'd9) d.busy = 1'b0;
            else                d.nbit = q.nbit + 4'd1;
        end else begin
            d.bcnt = q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1, default: '0};
        else        q <= d;
    end

    assign busy = q.busy;
    assign txd  = q.sh[0];

    a_r8_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
    a_r8_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> txd);
endmodule

// File: rtl/tcp_ack_reporter.sv
module tcp_ack_reporter #(
    parameter int PERIOD_CYC   = 5_000_000,
    parameter int CLKS_PER_BIT = 217
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mii_rxd,
    input  logic       mii_rx_dv,
    input  logic       mii_rx_er,
    output logic       uart_txd
);
    logic        byte_vld, frm_end, frm_err, tx_go, uart_busy;
    logic [7:0]  byte_dat, tx_byte;
    logic [31:0] ack_val;

    ackrep_nibble_asm u_nib (
        .clk(clk), .rst_n(rst_n), .rxd(mii_rxd), .rx_dv(mii_rx_dv), .rx_er(mii_rx_er),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .frm_end(frm_end), .frm_err(frm_err)
    );

    ackrep_frame_parser u_parse (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .frm_end(frm_end), .frm_err(frm_err), .ack_val(ack_val)
    );

    ackrep_report_ctrl #(.PERIOD_CYC(PERIOD_CYC)) u_rep (
        .clk(clk), .rst_n(rst_n), .ack_val(ack_val), .uart_busy(uart_busy),
        .tx_go(tx_go), .tx_byte(tx_byte)
    );

    ackrep_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_uart (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .din(tx_byte),
        .busy(uart_busy), .txd(uart_txd)
    );
endmodule

// File: tb/tcp_ack_reporter_tb_top.sv
module tcp_ack_reporter_tb_top;
    localparam int PERIOD = 3000;
    localparam int CPB    = 8;
    localparam int NREP   = 10;
    localparam int WDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       dv = 1'b0;
    logic       er = 1'b0;
    logic       txd;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rep_starts = 0;
    int last_start = 0;
    bit mon_done = 1'b0;
    bit timed_out = 1'b0;
    logic [31:0] expq[$];
    logic [7:0]  fr[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tcp_ack_reporter #(.PERIOD_CYC(PERIOD), .CLKS_PER_BIT(CPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .mii_rxd(rxd), .mii_rx_dv(dv),
        .mii_rx_er(er), .uart_txd(txd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build_frame(input logic [15:0] etype, input logic [7:0] verihl,
                               input logic [7:0] proto, input logic [31:0] ack,
                               input logic [7:0] flags, input int keep);
        int n;
        fr.delete();
        for (int i = 0; i < 6; i++) fr.push_back(8'h10 + 8'(i));
        for (int i = 0; i < 6; i++) fr.push_back(8'h20 + 8'(i));
        fr.push_back(etype[15:8]);
        fr.push_back(etype[7:0]);
        n = 4 * int'(verihl[3:0]);
        for (int i = 0; i < n; i++)
            fr.push_back(i == 0 ? verihl : (i == 9 ? proto : 8'h40 + 8'(i)));
        for (int i = 0; i < 20; i++) begin
            if (i >= 4 && i < 8)       fr.push_back(8'h70 + 8'(i));
            else if (i >= 8 && i < 12) fr.push_back(ack[8*(11-i) +: 8]);
            else if (i == 12)          fr.push_back(8'h50);
            else if (i == 13)          fr.push_back(flags);
            else                       fr.push_back(8'h60 + 8'(i));
        end
        for (int i = 0; i < 6; i++) fr.push_back(8'hC0 + 8'(i));
        if (keep > 0) while (fr.size() > keep) void'(fr.pop_back());
    endtask

    task automatic send_frame(input int pre_nibs, input int er_at);
        for (int i = 0; i < pre_nibs; i++) begin
            @(negedge clk); dv = 1'b1; rxd = 4'h5;
        end
        @(negedge clk); rxd = 4'hD;
        for (int i = 0; i < fr.size(); i++) begin
            @(negedge clk); rxd = fr[i][3:0]; er = (i == er_at);
            @(negedge clk); rxd = fr[i][7:4];
        end
        @(negedge clk); dv = 1'b0; er = 1'b0; rxd = 4'h0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_report(input int n);
        while (rep_starts < n) @(negedge clk);
    endtask

    // Monitor: decode serial reports and compare with the scoreboard queue.
    initial begin
        logic [31:0] word;
        logic [7:0]  b;
        wait (rst_n);
        for (int r = 0; r < NREP; r++) begin
            word = '0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                while (txd) @(negedge clk);
                if (k == 0) begin
                    if (r > 0)
                        check(cyc - last_start == PERIOD, "R7 report spacing",
                              32'(cyc - last_start), 32'(PERIOD));
                    last_start = cyc;
                    rep_starts++;
                end
                repeat (CPB/2) @(negedge clk);
                check(txd == 1'b0, "R8 start bit", {31'd0, txd}, 32'd0);
                for (int j = 0; j < 8; j++) begin
                    repeat (CPB) @(negedge clk);
                    b[j] = txd;
                end
                repeat (CPB) @(negedge clk);
                check(txd == 1'b1, "R8 stop bit", {31'd0, txd}, 32'd1);
                word = {word[23:0], b};
            end
            if (expq.size() == 0) begin
                check(1'b0, "R6 R9 scoreboard empty", word, 32'hxxxxxxxx);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                check(word == e, $sformatf("R6 R9 report %0d value", r), word, e);
            end
        end
        mon_done = 1'b1;
    end

    initial begin
        while (cyc < WDOG) @(negedge clk);
        timed_out = 1'b1;
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1 idle during reset", {31'd0, txd}, 32'd1);
        rst_n = 1'b1;
        expq.push_back(32'h0);                      // R1 first report is zero
        wait_report(1);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h11223344, 8'h10, 0);
        send_frame(15, -1);                          // R3 R4 plain capture, R9 overlap
        expq.push_back(32'h11223344);
        wait_report(2);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h00000100, 8'h18, 0);
        send_frame(15, -1);
        build_frame(16'h0800, 8'h45, 8'h06, 32'hDEADBEEF, 8'h10, 0);
        send_frame(15, -1);                          // R6 last one wins
        expq.push_back(32'hDEADBEEF);
        wait_report(3);
        build_frame(16'h0806, 8'h45, 8'h06, 32'h55555555, 8'h10, 0);
        send_frame(15, -1);                          // R3 wrong type
        expq.push_back(32'hDEADBEEF);
        wait_report(4);
        build_frame(16'h0800, 8'h45, 8'h11, 32'h66666666, 8'h10, 0);
        send_frame(15, -1);                          // R3 wrong protocol
        expq.push_back(32'hDEADBEEF);
        wait_report(5);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h77777777, 8'h02, 0);
        send_frame(15, -1);                          // R5 ACK flag clear
        expq.push_back(32'hDEADBEEF);
        wait_report(6);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h88888888, 8'h10, 0);
        send_frame(15, 50);                          // R5 rx error
        expq.push_back(32'hDEADBEEF);
        wait_report(7);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h99999999, 8'h10, 46);
        send_frame(15, -1);                          // R5 truncated before flags
        expq.push_back(32'hDEADBEEF);
        wait_report(8);
        build_frame(16'h0800, 8'h46, 8'h06, 32'h0A0B0C0D, 8'h10, 0);
        send_frame(5, -1);                           // R2 short preamble, R4 IHL 6
        expq.push_back(32'h0A0B0C0D);
        wait_report(9);
        build_frame(16'h0800, 8'h45, 8'h06, 32'h01020304, 8'h10, 0);
        send_frame(15, -1);
        build_frame(16'h0800, 8'h65, 8'h06, 32'hBBBBBBBB, 8'h10, 0);
        send_frame(15, -1);                          // R3 version not 4
        expq.push_back(32'h01020304);
        wait (mon_done || timed_out);
        if (timed_out && !mon_done)
            check(1'b0, "R7 watchdog expired", 32'(rep_starts), 32'(NREP));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule